// File: doc/BRIEF.md
# 1-Wire Bus Master Host Register Interface

This block is the processor-side register file of a 1-Wire bus master. The host reaches six internal registers through two byte locations: an index register, whose low three bits pick a register, and a data port that reads or writes the picked register. Behind the data port sit a command register, a shared transmit/receive buffer location, a read-only interrupt flag register, an interrupt enable register, a clock divisor register and a control register.

The line timing engine is a separate block. It receives the transmit byte, the command bits, the divisor setting and the control bits from this block. It returns a received byte and pulses that set or clear individual flags. This block merges those pulses with the side effects of host accesses and forms a single interrupt request.

Top module: `owm_host_regs`

## Requirements
- R1: Only bits 2:0 of the written index value select a register: 000 command, 001 buffer, 010 flags, 011 enables, 100 divisor, 101 control. Bits 7:3 have no effect on the selection.
- R2: Index codes 110 and 111 are unsupported. A data write at either code changes no register, and a read at either code returns 8'h00.
- R3: A data write at index 001 loads the transmit byte, which appears on `tx_byte` on the next cycle. A read at index 001 returns the receive byte and never the transmit byte.
- R4: The flag register is read-only, and data writes at index 010 leave it unchanged. Its bits are: 7 line-low, 6 short, 5 search reset, 4 receive full, 3 transmit empty, 2 transmit buffer empty, 1 presence result, 0 presence detect.
- R5: The enable register keeps bits 7:2 and 0 as written. Bit 1 is not implemented: it reads 0 and ignores writes.
- R6: The command register keeps only bits 3:0. The divisor register keeps bit 7 (clock enable), bits 4:2 (divider) and bits 1:0 (prescaler), and bits 6:5 read 0. The control register keeps all 8 bits, with bit 7 as the master interrupt enable. Each kept value also drives its output port.
- R7: A data write at index 001 clears flag bit 2 on the next cycle. A read strobe at index 001 clears flag bit 4. A read strobe at any other index does not clear bit 4. An engine set pulse in the same cycle overrides either clear.
- R8: A pulse on `eng_rx_valid` loads `eng_rx_data` into the receive byte and sets flag bit 4 on the next cycle.
- R9: `irq` equals control bit 7 AND the OR over all bits of (flags AND enables). Because enable bit 1 does not exist, flag bit 1 never raises `irq`.
- R10: After a synchronous active-low reset, every register reads 0 except the flags, which read 8'h0C. The index register is 0, and `irq` and all output ports are 0.
- R11: The engine sets flag bits with `eng_flag_set` and clears them with `eng_flag_clr`. When both pulse the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_we | input | 1 | Write strobe for the index register |
| addr_wdata | input | 8 | Index value; only bits 2:0 decoded |
| data_we | input | 1 | Write strobe for the selected register |
| data_re | input | 1 | Read strobe (side effects only) |
| data_wdata | input | 8 | Data written to the selected register |
| data_rdata | output | 8 | Selected register contents, combinational |
| eng_flag_set | input | 8 | Per-bit flag set pulses from the engine |
| eng_flag_clr | input | 8 | Per-bit flag clear pulses from the engine |
| eng_rx_valid | input | 1 | Received byte strobe |
| eng_rx_data | input | 8 | Received byte |
| tx_byte | output | 8 | Transmit byte to the engine |
| cmd_bits | output | 4 | Command bits: line input, force line, search, reset |
| clkdiv_bits | output | 8 | Divisor register contents |
| ctrl_bits | output | 8 | Control register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle: that no register changes after a write at an unsupported index, that unsupported reads return zero, that host writes leave the flags intact, that the host-side clears and the engine-side sets take effect, and that `irq` stays low while the master enable is off. The mapping of each index to its register, the masks on every field, and the exact interrupt equation over every flag pattern can only be shown by the bench's sweeps. The same holds for reset contents and the ordering of same-cycle clear and set events. The sweeps compare each result against values the bench computes arithmetically.

// File: rtl/owm_pkg.sv
// Package: shared constants for the 1-Wire host register interface.
// Assumes byte-wide registers and a 3-bit register index.
package owm_pkg;
    localparam int REG_W    = 8;
    localparam int IDX_W    = 3;
    localparam int NUM_REGS = 6;

    localparam logic [IDX_W-1:0] IDX_CMD  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_BUF  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_FLG  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_IEN  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_DIV  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CTL  = 3'd5;

    localparam logic [REG_W-1:0] MASK_CMD = 8'h0F;
    localparam logic [REG_W-1:0] MASK_IEN = 8'hFD;
    localparam logic [REG_W-1:0] MASK_DIV = 8'h9F;
    localparam logic [REG_W-1:0] MASK_CTL = 8'hFF;
    localparam logic [REG_W-1:0] MASK_BUF = 8'hFF;

    localparam logic [REG_W-1:0] FLAG_RST = 8'h0C;
    localparam int FLG_TBE  = 2;
    localparam int FLG_RBF  = 4;
    localparam int CTL_MIE  = 7;
endpackage

// File: rtl/owm_addr_dec.sv
// Module: index register and decoder.
// Holds the last written index and turns its low bits into a one-hot
// select over the implemented registers. Assumes upper index bits are don't-care.
module owm_addr_dec
    import owm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_we,
    input  logic [ADDR_W-1:0]   addr_wdata,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] sel,
    output logic                valid
);
    logic [IDX_W-1:0] idx_q;
    logic             unused_hi;

    assign unused_hi = ^addr_wdata[ADDR_W-1:IDX_W];

    // Capture the register index on a host index write.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (addr_we) idx_q <= addr_wdata[IDX_W-1:0];
    end

    // One select line per implemented register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = (idx_q == IDX_W'(g));
    end

    assign idx   = idx_q;
    assign valid = |sel;

    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    a_r2_invalid_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q >= IDX_W'(NUM_REGS)) |-> !valid);
endmodule

// File: rtl/owm_mask_reg.sv
// Module: byte register with a fixed implemented-bit mask.
// Unimplemented bits are constant 0 and ignore writes. Assumes MASK and RST are constants.
module owm_mask_reg #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   MASK = '1,
    parameter logic [W-1:0]   RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic unused_d;
    assign unused_d = ^(d & ~MASK);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (MASK[b]) begin : g_impl
            // Store an implemented bit.
            always_ff @(posedge clk) begin
                if (!rst_n)  q[b] <= RST[b];
                else if (we) q[b] <= d[b];
            end
        end else begin : g_tie
            assign q[b] = 1'b0;
        end
    end
endmodule

// File: rtl/owm_flag_bank.sv
// Module: interrupt flags, receive byte and interrupt request.
// Flags change only through engine pulses and host buffer side effects.
// Sets dominate clears within a cycle.
module owm_flag_bank
    import owm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_tx_wr,
    input  logic             host_rx_rd,
    input  logic [REG_W-1:0] eng_set,
    input  logic [REG_W-1:0] eng_clr,
    input  logic             eng_rx_valid,
    input  logic [REG_W-1:0] eng_rx_data,
    input  logic [REG_W-1:0] ien,
    input  logic             mie,
    output logic [REG_W-1:0] flags,
    output logic [REG_W-1:0] rx_byte,
    output logic             irq
);
    logic [REG_W-1:0] flags_q, rx_q, clr_all, set_all;

    // Merge engine and host clear/set sources.
    always_comb begin
        clr_all = eng_clr;
        clr_all[FLG_TBE] = eng_clr[FLG_TBE] | host_tx_wr;
        clr_all[FLG_RBF] = eng_clr[FLG_RBF] | host_rx_rd;
        set_all = eng_set;
        set_all[FLG_RBF] = eng_set[FLG_RBF] | eng_rx_valid;
    end

    // Update flags with sets winning over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= FLAG_RST;
        else        flags_q <= (flags_q & ~clr_all) | set_all;
    end

    // Capture a received byte from the engine.
    always_ff @(posedge clk) begin
        if (!rst_n)            rx_q <= '0;
        else if (eng_rx_valid) rx_q <= eng_rx_data;
    end

    assign flags   = flags_q;
    assign rx_byte = rx_q;
    assign irq     = mie & (|(flags_q & ien & MASK_IEN));

    a_r7_tbe_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_wr && !eng_set[FLG_TBE]) |=> !flags_q[FLG_TBE]);
    a_r7_rbf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rx_rd && !eng_set[FLG_RBF] && !eng_rx_valid) |=> !flags_q[FLG_RBF]);
    a_r8_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_valid |=> (flags_q[FLG_RBF] && rx_q == $past(eng_rx_data)));
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_set != '0) |=> ((flags_q & $past(eng_set)) == $past(eng_set)));
    a_r9_mie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !mie |-> !irq);
endmodule

// File: rtl/owm_host_regs.sv
// Module: top of the 1-Wire master host register interface.
// Decodes the index, stores configuration, routes the split buffer
// and forms the read data. Assumes one host access per cycle.
module owm_host_regs
    import owm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [REG_W-1:0]  data_wdata,
    output logic [REG_W-1:0]  data_rdata,
    input  logic [REG_W-1:0]  eng_flag_set,
    input  logic [REG_W-1:0]  eng_flag_clr,
    input  logic              eng_rx_valid,
    input  logic [REG_W-1:0]  eng_rx_data,
    output logic [REG_W-1:0]  tx_byte,
    output logic [3:0]        cmd_bits,
    output logic [REG_W-1:0]  clkdiv_bits,
    output logic [REG_W-1:0]  ctrl_bits,
    output logic              irq
);
    logic [IDX_W-1:0]    idx;
    logic [NUM_REGS-1:0] sel;
    logic                valid;
    logic [REG_W-1:0]    cmd_q, tx_q, ien_q, div_q, ctl_q, flags, rx_byte;

    owm_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .idx(idx), .sel(sel), .valid(valid)
    );

    owm_mask_reg #(.W(REG_W), .MASK(MASK_CMD), .RST('0)) u_cmd (
        .clk(clk), .rst_n(rst_n), .we(data_we & sel[IDX_CMD]),
        .d(data_wdata), .q(cmd_q));
    owm_mask_reg #(.W(REG_W), .MASK(MASK_BUF), .RST('0)) u_tx (
        .clk(clk), .rst_n(rst_n), .we(data_we & sel[IDX_BUF]),
        .d(data_wdata), .q(tx_q));
    owm_mask_reg #(.W(REG_W), .MASK(MASK_IEN), .RST('0)) u_ien (
        .clk(clk), .rst_n(rst_n), .we(data_we & sel[IDX_IEN]),
        .d(data_wdata), .q(ien_q));
    owm_mask_reg #(.W(REG_W), .MASK(MASK_DIV), .RST('0)) u_div (
        .clk(clk), .rst_n(rst_n), .we(data_we & sel[IDX_DIV]),
        .d(data_wdata), .q(div_q));
    owm_mask_reg #(.W(REG_W), .MASK(MASK_CTL), .RST('0)) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(data_we & sel[IDX_CTL]),
        .d(data_wdata), .q(ctl_q));

    owm_flag_bank u_flg (
        .clk(clk), .rst_n(rst_n),
        .host_tx_wr(data_we & sel[IDX_BUF]),
        .host_rx_rd(data_re & sel[IDX_BUF]),
        .eng_set(eng_flag_set), .eng_clr(eng_flag_clr),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
        .ien(ien_q), .mie(ctl_q[CTL_MIE]),
        .flags(flags), .rx_byte(rx_byte), .irq(irq)
    );

    // Select the read value; buffer reads return the receive byte.
    always_comb begin
        case (idx)
            IDX_CMD: data_rdata = cmd_q;
            IDX_BUF: data_rdata = rx_byte;
            IDX_FLG: data_rdata = flags;
            IDX_IEN: data_rdata = ien_q;
            IDX_DIV: data_rdata = div_q;
            IDX_CTL: data_rdata = ctl_q;
            default: data_rdata = '0;
        endcase
    end

    assign tx_byte     = tx_q;
    assign cmd_bits    = cmd_q[3:0];
    assign clkdiv_bits = div_q;
    assign ctrl_bits   = ctl_q;

    a_r2_invalid_write: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !valid) |=> ($stable(cmd_q) && $stable(tx_q) && $stable(ien_q)
                                 && $stable(div_q) && $stable(ctl_q)));
    a_r2_invalid_read: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (data_rdata == '0));
    a_r4_flags_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && sel[IDX_FLG] && !data_re && eng_flag_set == '0
         && eng_flag_clr == '0 && !eng_rx_valid) |=> $stable(flags));
endmodule

// File: tb/sim_owm_host_regs.sv
module sim_owm_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_we = 1'b0, data_we = 1'b0, data_re = 1'b0, eng_rx_valid = 1'b0;
    logic [7:0] addr_wdata = '0, data_wdata = '0, eng_flag_set = '0, eng_flag_clr = '0;
    logic [7:0] eng_rx_data = '0;
    logic [7:0] data_rdata, tx_byte, clkdiv_bits, ctrl_bits;
    logic [3:0] cmd_bits;
    logic       irq;
    int nchk = 0, nerr = 0;
    logic [7:0] e_cmd, e_tx, e_ien, e_div, e_ctl, e_flg, e_rx;

    always #5 clk = ~clk;

    owm_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .data_we(data_we), .data_re(data_re), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .eng_flag_set(eng_flag_set),
        .eng_flag_clr(eng_flag_clr), .eng_rx_valid(eng_rx_valid),
        .eng_rx_data(eng_rx_data), .tx_byte(tx_byte), .cmd_bits(cmd_bits),
        .clkdiv_bits(clkdiv_bits), .ctrl_bits(ctrl_bits), .irq(irq)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic set_addr(input logic [7:0] a);
        addr_we = 1'b1; addr_wdata = a; cyc(); addr_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        data_we = 1'b1; data_wdata = d; cyc(); data_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
        set_addr(a);
        chk(tag, data_rdata, exp);
    endtask

    task automatic peek_all(input string tag);
        peek(8'h00, e_cmd, {tag, " R1 R6 cmd"});
        peek(8'h09, e_rx,  {tag, " R1 R3 buf"});
        peek(8'h12, e_flg, {tag, " R1 R4 flags"});
        peek(8'hE3, e_ien, {tag, " R1 R5 ien"});
        peek(8'h04, e_div, {tag, " R1 R6 div"});
        peek(8'h7D, e_ctl, {tag, " R1 R6 ctl"});
        peek(8'h06, 8'h00, {tag, " R2 read 110"});
        peek(8'hFF, 8'h00, {tag, " R2 read 111"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        e_cmd = 0; e_tx = 0; e_ien = 0; e_div = 0; e_ctl = 0; e_flg = 8'h0C; e_rx = 0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R10 reset contents
        chk("R10 irq", {7'd0, irq}, 8'h00);
        chk("R10 tx_byte", tx_byte, 8'h00);
        chk("R10 index 0 reads cmd", data_rdata, 8'h00);
        peek_all("R10 reset");

        // R1 R2 R3 R5 R6 sweep: every index with every data byte
        for (int i = 0; i < 8; i++) begin
            for (int d = 0; d < 256; d++) begin
                logic [7:0] a;
                a = {5'(d * 7 + i), 3'(i)};
                set_addr(a);
                wr(8'(d));
                case (i)
                    0: e_cmd = 8'(d) & 8'h0F;
                    1: begin e_tx = 8'(d); e_flg[2] = 1'b0; end
                    3: e_ien = 8'(d) & 8'hFD;
                    4: e_div = 8'(d) & 8'h9F;
                    5: e_ctl = 8'(d);
                    default: ;
                endcase
                chk("R3 tx_byte port", tx_byte, e_tx);
                chk("R6 cmd_bits port", {4'd0, cmd_bits}, e_cmd);
                chk("R6 clkdiv port", clkdiv_bits, e_div);
                chk("R6 ctrl port", ctrl_bits, e_ctl);
                if (d % 16 == 0 || i >= 6) peek_all("sweep");
            end
        end

        // R9 R11 interrupt sweep over all flag patterns
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] en;
                en = (k == 0) ? 8'hFF : (k == 1) ? 8'h02 : (k == 2) ? 8'h10 :
                     (k == 3) ? 8'h81 : 8'h5C;
                set_addr(8'h03); wr(en); e_ien = en & 8'hFD;
                set_addr(8'h05); wr({m[0], 7'h00}); e_ctl = {m[0], 7'h00};
                set_addr(8'h02);
                for (int f = 0; f < 256; f++) begin
                    eng_flag_clr = 8'hFF; eng_flag_set = 8'(f);
                    cyc();
                    eng_flag_clr = 8'h00; eng_flag_set = 8'h00;
                    chk("R11 set wins over clear", data_rdata, 8'(f));
                    chk("R9 irq", {7'd0, irq},
                        {7'd0, m[0] & (|(8'(f) & e_ien & 8'hFD))});
                end
            end
        end
        e_flg = 8'hFF;

        // R4 flag register ignores host writes
        set_addr(8'h02); wr(8'h00);
        chk("R4 flags after write", data_rdata, 8'hFF);
        eng_flag_clr = 8'hFF; cyc(); eng_flag_clr = 8'h00;
        chk("R11 clear pulses", data_rdata, 8'h00);
        wr(8'h5A);
        chk("R4 flags after write 2", data_rdata, 8'h00);

        // R7 buffer write clears transmit-buffer-empty
        eng_flag_set = 8'h04; cyc(); eng_flag_set = 8'h00;
        set_addr(8'h01); wr(8'hA5);
        chk("R3 tx after buffer write", tx_byte, 8'hA5);
        chk("R3 buffer read is not tx", data_rdata, 8'h00);
        peek(8'h02, 8'h00, "R7 tbe cleared");
        set_addr(8'h01);
        data_we = 1'b1; data_wdata = 8'h3C; eng_flag_set = 8'h04; cyc();
        data_we = 1'b0; eng_flag_set = 8'h00;
        peek(8'h02, 8'h04, "R7 engine set beats tbe clear");

        // R8 receive load
        eng_rx_valid = 1'b1; eng_rx_data = 8'hC3; cyc(); eng_rx_valid = 1'b0;
        chk("R8 rbf set", data_rdata, 8'h14);
        peek(8'h01, 8'hC3, "R8 rx byte");
        chk("R3 tx kept", tx_byte, 8'h3C);

        // R7 read strobe at other index leaves rbf
        set_addr(8'h04); data_re = 1'b1; cyc(); data_re = 1'b0;
        peek(8'h02, 8'h14, "R7 read elsewhere keeps rbf");
        set_addr(8'h01); data_re = 1'b1; cyc(); data_re = 1'b0;
        peek(8'h02, 8'h04, "R7 buffer read clears rbf");
        peek(8'h01, 8'hC3, "R8 rx byte kept");
        data_re = 1'b1; eng_rx_valid = 1'b1; eng_rx_data = 8'h96; cyc();
        data_re = 1'b0; eng_rx_valid = 1'b0;
        chk("R8 new rx byte", data_rdata, 8'h96);
        peek(8'h02, 8'h14, "R7 rx load beats rbf clear");

        // R2 invalid writes change nothing
        e_flg = 8'h14; e_rx = 8'h96; e_tx = 8'h3C;
        set_addr(8'h06); wr(8'hFF);
        set_addr(8'hFF); wr(8'h55);
        chk("R2 tx unchanged", tx_byte, e_tx);
        peek_all("R2 after invalid writes");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule